// File: doc/BRIEF.md
# L2 Way Tag Store for an L1 Data Cache

This block is a small synchronous store kept beside an L1 data cache. It has one entry for each L1 set. Each entry records which L2 way holds the copy of that L1 line, and stores that way as a binary number. When the L2 fills a line into the L1, the way register supplies the L2 way number, and the store writes it into the entry addressed by the L1 set index. When the L1 later takes a write hit, the store reads the entry and returns the way number. The way number then travels with the write-through data, so the L2 needs to enable only that one way instead of all of them.

Two control inputs choose the operation each cycle. `acc_qual` qualifies the access. `acc_upd` chooses between writing (fill) and reading (write hit). Each entry carries a valid flag. Reset clears every flag, and a fill sets the flag of its entry. A read returns a registered result one cycle later, with a strobe and a flag that tells whether the entry held a recorded way.

Top module: `wtag_store`

## Requirements
- R1: A synchronous active-low reset marks every entry as not recorded and drives `rsp_vld`, `rsp_hit` and `rsp_way` to 0.
- R2: With `acc_qual`=1 and `acc_upd`=1 on a rising edge, the entry at `acc_idx` is written with `fill_way` and marked as recorded.
- R3: With `acc_qual`=1 and `acc_upd`=0 on a rising edge, the entry at `acc_idx` is read. After that edge, `rsp_vld`=1, `rsp_hit`=1 and `rsp_way` shows the stored way number.
- R4: A read of an entry that has not been recorded returns `rsp_hit`=0 and `rsp_way`=0.
- R5: With `acc_qual`=0, no entry is read or written, whatever the value of `acc_upd` and the other inputs.
- R6: `rsp_vld` is 1 for exactly the cycle after each read edge, and 0 after write and idle edges.
- R7: A later fill overwrites an earlier one. A read on the edge right after a write to the same index returns the newly written way.
- R8: A write changes only the entry at its own index. All other entries keep their way number and their recorded state.
- R9: `rsp_way` and `rsp_hit` keep the result of the last read until the next read.
- R10: The way number is log2(number of L2 ways) bits wide. Every value, including 0 and the largest way, is stored and returned exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_qual | input | 1 | Access qualifier: 1 = write hit or fill access |
| acc_upd | input | 1 | With the qualifier set: 1 = write entry, 0 = read entry |
| acc_idx | input | IDX_W (6) | L1 set index |
| fill_way | input | WAY_W (2) | L2 way number from the way register, used on writes |
| rsp_vld | output | 1 | Read result valid, one cycle after the read |
| rsp_hit | output | 1 | The entry that was read had been recorded |
| rsp_way | output | WAY_W (2) | Way number that was read (0 when not recorded) |

## Verification
The hardest case to produce from the ports is R5 together with R8. A disabled access that has `acc_upd` set must leave the store untouched, and that can only be seen through a later read of the same index. To reach it, random operations run over a deliberately narrow index window, so that idle cycles, fills and reads land on the same entries many times. A bench model of every entry then checks each read result. Directed sequences add the cases that random stimulus rarely hits on its own. These are a read on the edge right after a write to the same index, the first and last index, the largest way number, and reads of entries never filled since reset.

// File: rtl/wtag_pkg.sv
// Shared types for the way tag store: the operation chosen by the two
// access controls and the function that derives it.
package wtag_pkg;

    typedef enum logic [1:0] {
        WT_IDLE  = 2'd0,
        WT_READ  = 2'd1,
        WT_WRITE = 2'd2
    } wt_op_e;

    // Qualifier low means no access; otherwise update picks write or read.
    function automatic wt_op_e wt_decode(input logic qual, input logic upd);
        if (!qual)
            return WT_IDLE;
        else if (upd)
            return WT_WRITE;
        else
            return WT_READ;
    endfunction

endpackage

// File: rtl/wtag_ctrl.sv
// Access control: turns the qualifier and update inputs into one write
// strobe and one read strobe. It assumes both inputs are sampled on the
// same edge as the index. At most one strobe is active in any cycle.
module wtag_ctrl
    import wtag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic qual,
    input  logic upd,
    output logic do_wr,
    output logic do_rd
);

    wt_op_e op;

    // Decode the requested operation from the two control inputs.
    always_comb begin
        op    = wt_decode(qual, upd);
        do_wr = (op == WT_WRITE);
        do_rd = (op == WT_READ);
    end

    // The store never sees a read and a write in the same cycle.
    assert_single_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_wr, do_rd}))
        else $error("read and write strobes both active");

endmodule

// File: rtl/wtag_entries.sv
// Entry storage: one way number and one recorded flag per L1 set. It
// assumes SETS is a power of two, so that every index value addresses an
// entry. Reset clears only the recorded flags. The way bits of an entry
// are meaningful only while its flag is set.
module wtag_entries #(
    parameter int SETS  = 64,
    parameter int WAY_W = 2,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [WAY_W-1:0] wr_way,
    output logic [WAY_W-1:0] rd_way,
    output logic             rd_rec
);

    logic [WAY_W-1:0] way_q [SETS];
    logic [SETS-1:0]  rec_q;
    logic [SETS-1:0]  sel;

    // One-hot select of the addressed entry.
    always_comb begin
        sel = '0;
        sel[idx] = 1'b1;
    end

    for (genvar e = 0; e < SETS; e++) begin : g_entry
        // Capture the new way number when this entry is filled.
        always_ff @(posedge clk) begin
            if (wr_en && sel[e])
                way_q[e] <= wr_way;
        end

        // Recorded flag: cleared by reset, set by a fill.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rec_q[e] <= 1'b0;
            else if (wr_en && sel[e])
                rec_q[e] <= 1'b1;
        end
    end

    // Combinational read of the addressed entry.
    always_comb begin
        rd_way = way_q[idx];
        rd_rec = rec_q[idx];
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (rec_q == '0))
        else $error("recorded flags not cleared by reset");

    assert_fill_records_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rec_q[$past(idx)] && (way_q[$past(idx)] == $past(wr_way)))
        else $error("fill not recorded");

    assert_no_write_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rec_q))
        else $error("recorded flags changed without a fill");

endmodule

// File: rtl/wtag_rsp.sv
// Read response register: holds the result of the most recent read and
// raises a strobe for one cycle after each read. An entry that was never
// recorded is returned as way 0 with the hit flag low. Between reads, the
// way and hit outputs hold their last value.
module wtag_rsp #(
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [WAY_W-1:0] ent_way,
    input  logic             ent_rec,
    output logic             rsp_vld,
    output logic             rsp_hit,
    output logic [WAY_W-1:0] rsp_way
);

    // Strobe that marks the cycle after a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_vld <= 1'b0;
        else
            rsp_vld <= rd_en;
    end

    // Register the read result, with the way masked for unrecorded entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit <= 1'b0;
            rsp_way <= '0;
        end else if (rd_en) begin
            rsp_hit <= ent_rec;
            rsp_way <= ent_rec ? ent_way : '0;
        end
    end

    assert_strobe_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rsp_vld)
        else $error("missing response strobe");

    assert_no_strobe_otherwise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rsp_vld)
        else $error("spurious response strobe");

    assert_miss_way_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_way == '0))
        else $error("way not zero on miss");

endmodule

// File: rtl/wtag_store.sv
// Way tag store top: for each L1 set, records the L2 way holding the line.
// A fill writes the way register value; a write hit reads it back one
// cycle later. Both controls are sampled on the rising clock edge, and
// reset is synchronous and active low.
module wtag_store #(
    parameter int L1_SETS = 64,
    parameter int L2_WAYS = 4,
    localparam int IDX_W  = (L1_SETS > 1) ? $clog2(L1_SETS) : 1,
    localparam int WAY_W  = (L2_WAYS > 1) ? $clog2(L2_WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_qual,
    input  logic             acc_upd,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic [WAY_W-1:0] fill_way,
    output logic             rsp_vld,
    output logic             rsp_hit,
    output logic [WAY_W-1:0] rsp_way
);

    logic             do_wr;
    logic             do_rd;
    logic [WAY_W-1:0] ent_way;
    logic             ent_rec;

    wtag_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .qual  (acc_qual),
        .upd   (acc_upd),
        .do_wr (do_wr),
        .do_rd (do_rd)
    );

    wtag_entries #(
        .SETS  (L1_SETS),
        .WAY_W (WAY_W),
        .IDX_W (IDX_W)
    ) u_entries (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (do_wr),
        .idx    (acc_idx),
        .wr_way (fill_way),
        .rd_way (ent_way),
        .rd_rec (ent_rec)
    );

    wtag_rsp #(
        .WAY_W (WAY_W)
    ) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (do_rd),
        .ent_way (ent_way),
        .ent_rec (ent_rec),
        .rsp_vld (rsp_vld),
        .rsp_hit (rsp_hit),
        .rsp_way (rsp_way)
    );

    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_qual |=> ($stable(rsp_way) && $stable(rsp_hit) && !rsp_vld))
        else $error("response changed on idle cycle");

    assert_write_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_qual && acc_upd) |=> ($stable(rsp_way) && $stable(rsp_hit)))
        else $error("response changed on fill");

endmodule

// File: tb/wtag_store_tb.sv
module wtag_store_tb;

    localparam int SETS = 64;
    localparam int WAYS = 4;
    localparam int IW   = $clog2(SETS);
    localparam int WW   = $clog2(WAYS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_qual = 1'b0;
    logic          acc_upd = 1'b0;
    logic [IW-1:0] acc_idx = '0;
    logic [WW-1:0] fill_way = '0;
    logic          rsp_vld;
    logic          rsp_hit;
    logic [WW-1:0] rsp_way;

    int checks = 0;
    int errors = 0;

    // Bench model of the store
    logic [WW-1:0] m_way [SETS];
    logic          m_rec [SETS];
    logic [WW-1:0] m_last_way;
    logic          m_last_hit;

    always #2 clk = ~clk;

    wtag_store #(.L1_SETS(SETS), .L2_WAYS(WAYS)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_qual(acc_qual), .acc_upd(acc_upd),
        .acc_idx(acc_idx), .fill_way(fill_way),
        .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_way(rsp_way)
    );

    function automatic logic [WW-1:0] exp_way(input int i);
        return m_rec[i] ? m_way[i] : '0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one operation on an edge, then compare the outputs against the model
    task automatic step(input logic q, input logic u, input int i, input int w, input string req);
        @(negedge clk);
        acc_qual = q; acc_upd = u; acc_idx = IW'(i); fill_way = WW'(w);
        @(posedge clk);
        #1;
        if (q && u) begin
            m_way[i] = WW'(w);
            m_rec[i] = 1'b1;
        end else if (q) begin
            m_last_way = exp_way(i);
            m_last_hit = m_rec[i];
        end
        check({req, " vld (R6)"}, int'(rsp_vld), int'(q && !u));
        check({req, " hit"}, int'(rsp_hit), int'(m_last_hit));
        check({req, " way"}, int'(rsp_way), int'(m_last_way));
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < SETS; i++) begin m_rec[i] = 1'b0; m_way[i] = '0; end
        m_last_way = '0; m_last_hit = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset vld", int'(rsp_vld), 0);
        check("R1 reset hit", int'(rsp_hit), 0);
        check("R1 reset way", int'(rsp_way), 0);
        @(negedge clk); rst_n = 1'b1;

        // R1 R4: reads after reset find nothing recorded
        step(1, 0, 0, 0, "R1 R4 read idx0");
        step(1, 0, SETS-1, 0, "R1 R4 read last");
        // R2 R3 R10: fill then read, boundary index and max way
        step(1, 1, SETS-1, WAYS-1, "R2 fill last");
        step(1, 0, SETS-1, 0, "R3 R10 read last");
        step(1, 1, 0, 0, "R2 fill idx0 way0");
        step(1, 0, 0, 0, "R10 read way0");
        // R7: overwrite and read immediately after write
        step(1, 1, 5, 1, "R7 fill");
        step(1, 1, 5, 2, "R7 overwrite");
        step(1, 0, 5, 0, "R7 read after write");
        // R5: idle with update set does not write
        step(0, 1, 9, 3, "R5 idle upd1");
        step(0, 0, 9, 3, "R5 idle upd0");
        step(1, 0, 9, 0, "R5 R4 read untouched");
        // R8: neighbour untouched
        step(1, 1, 6, 3, "R8 fill neighbour");
        step(1, 0, 5, 0, "R8 read idx5");
        // R9: idle after read holds
        step(0, 0, 7, 0, "R9 hold");

        // Random phase over a narrow index window
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom_range(0, 9));
            int i = int'($urandom_range(0, 7)) + ((n % 500 < 250) ? 0 : SETS - 8);
            int w = int'($urandom_range(0, WAYS-1));
            logic q = (r < 7);
            logic u = (r < 3) || (r == 9);
            step(q, u, i, w, "rand R2 R3 R5 R8");
        end

        // R1: reset again clears every entry
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 re-reset vld", int'(rsp_vld), 0);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < SETS; i++) m_rec[i] = 1'b0;
        m_last_way = '0; m_last_hit = 1'b0;
        step(1, 0, 6, 0, "R1 read after re-reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule